// File: doc/BRIEF.md
# Dual-Personality Disk Controller Register Front End

This block is the register front end of a floppy disk controller that can run in two personalities. After reset it is in a legacy soft-switch personality. In that personality no register holds data for the bus. Every access, whether a read or a write, sets or clears one of eight single-bit switches, and the byte address selects which one. When both shift-control switches are set, a write is steered into a data latch or a mode latch, depending on the motor switch. A fixed four-value key written into the mode latch moves the block into an extended personality. It stays there until the next reset.

In the extended personality the same address window becomes a small register map. It holds a phase register, a mode register that is modified through separate clear and set addresses, and a handshake status byte. The handshake byte reports the sense bit only when the phase register holds the drive-present select code. Register slots that are not implemented read as zero and ignore writes. The switch, latch and register contents leave the block as plain outputs so that the drive-side logic can use them.

Top module: `dskc_regfront`

## Requirements
- R1: The register index is byte-address bits [12:9]. Address bits [8:0] have no effect, which gives 16 slots across a 0x2000-byte window.
- R2: In legacy mode, every read or write loads index bit 0 into the switch that index bits [3:1] select. Select 0 to 3 are phase switches 0 to 3, select 4 is motor, 5 is drive select, 6 is shift-control A and 7 is shift-control B. Switch k appears on `sw_latch[k]`.
- R3: In legacy mode, a write steers its data only when both shift-control switches are set, as they stand after that same write's switch update. If the motor switch is then set, the data goes to `leg_data`. Otherwise it goes to `leg_mode`.
- R4: Each write into the mode latch is compared against the key 0x57, 0x17, 0x57, 0x57, one value per step. A matching value advances the step. A value that does not match leaves the step unchanged.
- R5: The write that matches the fourth key value raises `ext_active`, which then stays high until reset. The step returns to 0. From then on, accesses no longer change the switches or the legacy latches.
- R6: In legacy mode, every read returns 0x00.
- R7: In extended mode, a write to index 4 loads the phase register. A write to index 6 clears each mode bit that is 1 in the data. A write to index 7 sets each mode bit that is 1 in the data.
- R8: In extended mode, a read of index 12 returns the phase register.
- R9: In extended mode, a read of index 15 returns 0x08 when the phase register equals 0x77, and 0x00 otherwise.
- R10: In extended mode, writes to indices 0, 1, 2, 3 and 5 change nothing. Reads of indices 8, 9, 10, 11, 13 and 14 return 0x00.
- R11: A synchronous active-high reset selects legacy mode and clears the key step, all switches, both legacy latches, the phase register, the mode register and `bus_rdata`.
- R12: Read data is registered and appears on `bus_rdata` one clock after the read strobe. It holds its value while no read is made. The switch change caused by a legacy read takes effect on that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address within the window |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Registered read data |
| sw_latch | output | 8 | Legacy soft-switch states |
| leg_data | output | 8 | Legacy data latch |
| leg_mode | output | 8 | Legacy mode latch |
| ext_active | output | 1 | Extended personality selected |
| ext_phase | output | 8 | Extended phase register |
| ext_mode | output | 8 | Extended mode register |

## Verification
Two functions act on the same legacy write. The address-selected switch update and the steering test that depends on the shift-control switches happen in one cycle, and steering must use the post-update switch values. The bench provokes this by writing to the index that sets shift-control B while shift-control A is already set, and then to the index that turns the motor on. It judges the result by which latch took the byte. A second collision is the key write that completes the unlock: it loads the mode latch and changes personality on one edge. The bench checks that the mode latch holds that key value and that the next access already decodes through the extended map.

// File: rtl/dskc_pkg.sv
package dskc_pkg;

    localparam int DW    = 8;
    localparam int IDX_W = 4;

    // switch selects, in the order index bits [3:1] decode them
    typedef enum logic [2:0] {
        SW_PH0, SW_PH1, SW_PH2, SW_PH3, SW_MOTOR, SW_DRIVE, SW_SHA, SW_SHB
    } sw_sel_e;

    typedef enum logic [1:0] {
        KEY_S0, KEY_S1, KEY_S2, KEY_S3
    } key_step_e;

    localparam logic [DW-1:0] KEY_MAIN    = 8'h57;
    localparam logic [DW-1:0] KEY_ALT     = 8'h17;
    localparam logic [DW-1:0] SENSE_PHASE = 8'h77;
    localparam logic [DW-1:0] SENSE_BIT   = 8'h08;

    localparam logic [IDX_W-1:0] IX_PHASE_WR = 4'd4;
    localparam logic [IDX_W-1:0] IX_MODE_CLR = 4'd6;
    localparam logic [IDX_W-1:0] IX_MODE_SET = 4'd7;
    localparam logic [IDX_W-1:0] IX_PHASE_RD = 4'd12;
    localparam logic [IDX_W-1:0] IX_HSHAKE   = 4'd15;

    typedef struct packed {
        logic             rd;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [DW-1:0]    wdata;
    } bus_req_t;

    function automatic logic [DW-1:0] key_expect(key_step_e s);
        return (s == KEY_S1) ? KEY_ALT : KEY_MAIN;
    endfunction

endpackage

// File: rtl/dskc_unlock.sv
module dskc_unlock
    import dskc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          key_wr,
    input  logic [DW-1:0] key,
    output logic          unlock
);

    key_step_e step_q;
    logic      hit;

    assign hit    = key_wr && (key == key_expect(step_q));
    assign unlock = hit && (step_q == KEY_S3);

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= KEY_S0;
        end else if (hit) begin
            step_q <= (step_q == KEY_S3) ? KEY_S0 : key_step_e'(step_q + 2'd1);
        end
    end

    // R4: a wrong key value keeps the step
    p_step_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (key_wr && key != key_expect(step_q)) |=> $stable(step_q));

    // R5: completion returns the detector to its first step
    p_step_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        unlock |=> (step_q == KEY_S0));

endmodule

// File: rtl/dskc_legacy.sv
module dskc_legacy
    import dskc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  bus_req_t      req,
    output logic [DW-1:0] sw_q,
    output logic [DW-1:0] data_q,
    output logic [DW-1:0] mode_q,
    output logic          mode_wr
);

    logic [DW-1:0] sw_n;
    logic          access;
    logic          steer;
    logic          data_wr;

    assign access = en && (req.rd || req.wr);

    always_comb begin
        sw_n = sw_q;
        if (access) begin
            sw_n[req.idx[IDX_W-1:1]] = req.idx[0];
        end
    end

    // steering sees the switches as this access leaves them
    assign steer   = en && req.wr && sw_n[SW_SHA] && sw_n[SW_SHB];
    assign data_wr = steer && sw_n[SW_MOTOR];
    assign mode_wr = steer && !sw_n[SW_MOTOR];

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q   <= '0;
            data_q <= '0;
            mode_q <= '0;
        end else begin
            sw_q <= sw_n;
            if (data_wr) data_q <= req.wdata;
            if (mode_wr) mode_q <= req.wdata;
        end
    end

    // R2: addressed switch takes index bit 0
    p_switch_load_r2: assert property (@(posedge clk) disable iff (rst)
        access |=> (sw_q[$past(req.idx[IDX_W-1:1])] == $past(req.idx[0])));

    // R3: motor-on write with both shift switches set lands in the data latch
    p_steer_data_r3: assert property (@(posedge clk) disable iff (rst)
        (en && req.wr && req.idx == 4'd9 && sw_q[SW_SHA] && sw_q[SW_SHB])
        |=> (data_q == $past(req.wdata)));

    // R5: a disabled personality leaves the switches alone
    p_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(sw_q) && $stable(data_q) && $stable(mode_q));

endmodule

// File: rtl/dskc_ext.sv
module dskc_ext
    import dskc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  bus_req_t      req,
    output logic [DW-1:0] phase_q,
    output logic [DW-1:0] mode_q,
    output logic [DW-1:0] rd_val
);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            mode_q  <= '0;
        end else if (en && req.wr) begin
            case (req.idx)
                IX_PHASE_WR: phase_q <= req.wdata;
                IX_MODE_CLR: mode_q  <= mode_q & ~req.wdata;
                IX_MODE_SET: mode_q  <= mode_q | req.wdata;
                default:     ;
            endcase
        end
    end

    always_comb begin
        case (req.idx)
            IX_PHASE_RD: rd_val = phase_q;
            IX_HSHAKE:   rd_val = (phase_q == SENSE_PHASE) ? SENSE_BIT : '0;
            default:     rd_val = '0;
        endcase
    end

    // R7: clear and set addresses act bitwise on the mode register
    p_mode_clr_r7: assert property (@(posedge clk) disable iff (rst)
        (en && req.wr && req.idx == 4'd6) |=> ((mode_q & $past(req.wdata)) == 8'h00));
    p_mode_set_r7: assert property (@(posedge clk) disable iff (rst)
        (en && req.wr && req.idx == 4'd7) |=> ((mode_q & $past(req.wdata)) == $past(req.wdata)));

    // R10: unimplemented write slots leave both registers untouched
    p_ignore_wr_r10: assert property (@(posedge clk) disable iff (rst)
        (en && req.wr && (req.idx < 4'd4 || req.idx == 4'd5))
        |=> $stable(phase_q) && $stable(mode_q));

endmodule

// File: rtl/dskc_regfront.sv
module dskc_regfront
    import dskc_pkg::*;
#(
    parameter int IDX_LSB = 9,
    localparam int ADDR_W = IDX_LSB + IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [DW-1:0]     bus_rdata,
    output logic [DW-1:0]     sw_latch,
    output logic [DW-1:0]     leg_data,
    output logic [DW-1:0]     leg_mode,
    output logic              ext_active,
    output logic [DW-1:0]     ext_phase,
    output logic [DW-1:0]     ext_mode
);

    bus_req_t      req;
    logic          key_wr;
    logic          unlock;
    logic [DW-1:0] ext_rd;

    assign req.rd    = bus_rd;
    assign req.wr    = bus_wr;
    assign req.idx   = bus_addr[IDX_LSB +: IDX_W];
    assign req.wdata = bus_wdata;

    dskc_legacy u_legacy (
        .clk     (clk),
        .rst     (rst),
        .en      (!ext_active),
        .req     (req),
        .sw_q    (sw_latch),
        .data_q  (leg_data),
        .mode_q  (leg_mode),
        .mode_wr (key_wr)
    );

    dskc_unlock u_unlock (
        .clk    (clk),
        .rst    (rst),
        .key_wr (key_wr),
        .key    (bus_wdata),
        .unlock (unlock)
    );

    dskc_ext u_ext (
        .clk     (clk),
        .rst     (rst),
        .en      (ext_active),
        .req     (req),
        .phase_q (ext_phase),
        .mode_q  (ext_mode),
        .rd_val  (ext_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_active <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            if (unlock) ext_active <= 1'b1;
            if (bus_rd) bus_rdata <= ext_active ? ext_rd : '0;
        end
    end

    // R5: extended personality is sticky
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        ext_active |=> ext_active);

    // R6: legacy reads return zero
    p_legacy_rd_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !ext_active) |=> (bus_rdata == 8'h00));

    // R8: phase read-back
    p_phase_rd_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ext_active && bus_addr[IDX_LSB +: IDX_W] == 4'd12)
        |=> (bus_rdata == $past(ext_phase)));

    // R9: handshake sense
    p_sense_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && ext_active && bus_addr[IDX_LSB +: IDX_W] == 4'd15)
        |=> (bus_rdata == (($past(ext_phase) == 8'h77) ? 8'h08 : 8'h00)));

    // R12: read data holds between reads
    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R11: reset clears the visible state
    p_reset_r11: assert property (@(posedge clk)
        rst |=> (!ext_active && sw_latch == 8'h00 && leg_data == 8'h00 &&
                 leg_mode == 8'h00 && ext_phase == 8'h00 && ext_mode == 8'h00 &&
                 bus_rdata == 8'h00));

endmodule

// File: tb/dskc_regfront_tb.sv
module dskc_regfront_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic [7:0]  sw_latch;
    logic [7:0]  leg_data;
    logic [7:0]  leg_mode;
    logic        ext_active;
    logic [7:0]  ext_phase;
    logic [7:0]  ext_mode;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dskc_regfront u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .sw_latch(sw_latch), .leg_data(leg_data), .leg_mode(leg_mode),
        .ext_active(ext_active), .ext_phase(ext_phase), .ext_mode(ext_mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // low offset bits vary to show they are dropped (R1)
    task automatic bus_write(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = {idx, 9'h0} | 13'({idx, 5'h0} ^ 9'h1A5);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 9'h0} | 13'(9'h0F3);
        bus_rd   = 1'b1;
        @(negedge clk);
        d      = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset sw", sw_latch, 8'h00);
        chk("R11 reset ext", {7'd0, ext_active}, 8'h00);
        chk("R11 reset rdata", bus_rdata, 8'h00);
        chk("R11 reset legmode", leg_mode, 8'h00);
    endtask

    task automatic t_switches();
        logic [7:0] d;
        bus_write(4'd1, 8'h00);
        bus_write(4'd3, 8'h00);
        bus_write(4'd5, 8'h00);
        chk("R2 write sets phase0..2", sw_latch, 8'h07);
        bus_read(4'd7, d);
        chk("R12 read side effect same edge", sw_latch, 8'h0F);
        chk("R6 legacy read zero", d, 8'h00);
        bus_read(4'd9, d);
        bus_read(4'd11, d);
        bus_write(4'd4, 8'hFF);
        chk("R2 mixed set/clear", sw_latch, 8'h3B);
        chk("R3 no steering without shift switches", leg_data, 8'h00);
        for (int i = 0; i < 12; i += 2) bus_write(4'(i), 8'h00);
        chk("R2 all cleared", sw_latch, 8'h00);
    endtask

    task automatic t_steer();
        bus_write(4'd13, 8'h21);
        chk("R3 only A set no steer", leg_mode, 8'h00);
        bus_write(4'd15, 8'h11);
        chk("R3 same-write B set steers to mode", leg_mode, 8'h11);
        chk("R2 shift switches", sw_latch, 8'hC0);
        bus_write(4'd9, 8'hAB);
        chk("R3 motor on steers to data", leg_data, 8'hAB);
        chk("R3 mode untouched", leg_mode, 8'h11);
        bus_write(4'd14, 8'h33);
        chk("R3 B cleared no steer data", leg_data, 8'hAB);
        chk("R3 B cleared no steer mode", leg_mode, 8'h11);
    endtask

    task automatic t_unlock();
        logic [7:0] d;
        bus_write(4'd8, 8'h57);
        chk("R3 motor off, B clear", leg_mode, 8'h11);
        bus_write(4'd15, 8'h57);
        bus_write(4'd15, 8'h57);
        bus_write(4'd15, 8'h99);
        bus_write(4'd15, 8'h17);
        bus_write(4'd15, 8'h57);
        chk("R4 mismatches hold, not yet unlocked", {7'd0, ext_active}, 8'h00);
        bus_read(4'd13, d);
        chk("R6 legacy read zero", d, 8'h00);
        bus_write(4'd15, 8'h57);
        chk("R5 unlocked", {7'd0, ext_active}, 8'h01);
        chk("R5 final key in mode latch", leg_mode, 8'h57);
        bus_write(4'd1, 8'h57);
        bus_read(4'd0, d);
        chk("R5 switches frozen", sw_latch, 8'hC0);
        chk("R5 mode latch frozen", leg_mode, 8'h57);
        chk("R5 sticky", {7'd0, ext_active}, 8'h01);
    endtask

    task automatic t_ext();
        logic [7:0] d;
        bus_write(4'd4, 8'h5A);
        chk("R7 phase load", ext_phase, 8'h5A);
        bus_read(4'd12, d);
        chk("R8 phase read", d, 8'h5A);
        bus_read(4'd15, d);
        chk("R9 no sense", d, 8'h00);
        bus_write(4'd4, 8'h77);
        bus_read(4'd15, d);
        chk("R9 sense", d, 8'h08);
        bus_write(4'd4, 8'h76);
        bus_read(4'd15, d);
        chk("R9 near miss", d, 8'h00);
        bus_write(4'd7, 8'hF0);
        chk("R7 set", ext_mode, 8'hF0);
        bus_write(4'd6, 8'h30);
        chk("R7 clear", ext_mode, 8'hC0);
        bus_write(4'd7, 8'h05);
        chk("R7 set keeps others", ext_mode, 8'hC5);
    endtask

    task automatic t_unimpl();
        logic [7:0] d;
        foreach (d[i]) ; // no-op keeps loop style uniform
        bus_write(4'd0, 8'hFF);
        bus_write(4'd1, 8'hFF);
        bus_write(4'd2, 8'hFF);
        bus_write(4'd3, 8'hFF);
        bus_write(4'd5, 8'hFF);
        chk("R10 ignored phase", ext_phase, 8'h76);
        chk("R10 ignored mode", ext_mode, 8'hC5);
        for (int i = 8; i < 15; i++) begin
            if (i != 12) begin
                bus_read(4'(i), d);
                chk("R10 unimplemented read", d, 8'h00);
            end
        end
    endtask

    task automatic t_hold();
        logic [7:0] d;
        bus_read(4'd12, d);
        chk("R12 read value", d, 8'h76);
        repeat (3) @(negedge clk);
        chk("R12 held", bus_rdata, 8'h76);
        bus_write(4'd4, 8'h01);
        chk("R12 held across write", bus_rdata, 8'h76);
    endtask

    task automatic t_rereset();
        logic [7:0] d;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R11 back to legacy", {7'd0, ext_active}, 8'h00);
        chk("R11 phase cleared", ext_phase, 8'h00);
        chk("R11 mode cleared", ext_mode, 8'h00);
        chk("R11 rdata cleared", bus_rdata, 8'h00);
        bus_write(4'd5, 8'h77);
        bus_read(4'd12, d);
        chk("R11 legacy decode after reset", sw_latch, 8'h04);
        chk("R6 read zero after reset", d, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_switches();
        t_steer();
        t_unlock();
        t_ext();
        t_unimpl();
        t_hold();
        t_rereset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule